// File: doc/BRIEF.md
# Guarded Nonvolatile Byte Access Controller

This block fronts a 64-byte nonvolatile store, held here as an internal array. Software reaches it through three 8-bit registers on a simple select/write bus: a byte pointer, a data buffer and a control word. A read is a single strobe. The strobe copies the pointed-to byte into the data buffer within one clock and asks the core to stall for four cycles.

Writes are guarded. Software first sets an arming bit, and that bit lapses by itself four cycles later. The write strobe counts only while the arming bit is still live. An accepted write makes the strobe bit a busy flag. The flag stays set until a fixed number of timing-oscillator ticks has elapsed, which the `osc_tick` clock-enable marks. The byte is then committed and the flag drops. Software may poll the flag, or it may use the ready interrupt, a plain level that is high whenever the interrupt is enabled and no write is busy. If software changes the pointer or the buffer during a busy write, the write is abandoned and the byte is left as it was.

The register bus is a plain control port with no back-pressure. A write (`reg_wr` high) takes effect at the clock edge. Read data is combinational from `reg_sel`.

Top module: `nvb_ctrl`

## Requirements
- R1: Select value 2 picks the pointer register. It holds 6 bits and reads back with bits 7..6 as zero. Reset does not clear it.
- R2: Select value 0 picks the control word. Bit 3 is interrupt enable, bit 2 is the arming bit, bit 1 is the write strobe / busy flag and bit 0 is the read strobe, which always reads 0. Bits 7..4 read 0. After reset the control word, the data buffer (select value 1), the stall output and the interrupt are all zero.
- R3: A control write with bit 2 set arms writes. The arming bit reads 1 for the following four cycles and clears at the fourth edge after the arming write. A write strobe at any of those four edges is accepted. A strobe at the fifth edge is not.
- R4: A control write with bit 1 set while the arming bit is clear has no effect: busy stays 0, no stall is requested and the store is unchanged.
- R5: An accepted write keeps bit 1 set until WRITE_TICKS `osc_tick` pulses have been seen in the cycles after acceptance. Cycles without a tick do not count. At the last tick the data buffer is committed to the pointed-to byte and bit 1 clears.
- R6: A control write with bit 0 set, while no write is busy, loads the data buffer from the pointed-to byte by the next cycle.
- R7: `stall_cycles` shows 4 for one cycle after an accepted read and 2 for one cycle after an accepted write. In every other cycle it shows 0.
- R8: `ready_irq` is high exactly when interrupt enable is set and bit 1 is clear.
- R9: Writing the pointer or the data buffer while busy clears bit 1 at that edge and leaves the target byte unchanged.
- R10: A read strobe while busy is ignored: the data buffer keeps its value and no stall is requested.
- R11: A write strobe while busy, even when armed, is ignored and does not restart the tick count.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| osc_tick | input | 1 | Timing-oscillator tick, clock enable for the write timer |
| reg_wr | input | 1 | Register write at this edge |
| reg_sel | input | 2 | Register select: 0 control, 1 data, 2 pointer, 3 none |
| reg_wdata | input | 8 | Register write data |
| reg_rdata | output | 8 | Read value of the selected register |
| stall_cycles | output | 3 | Requested core stall length, one-cycle pulse |
| ready_irq | output | 1 | Ready interrupt level |

## Verification
Several properties are checked on every cycle: the arming bit never outlives its four-cycle window, busy rises only when armed, an edit of the pointer or buffer during a busy write clears busy at once, stall codes match the request that caused them, the interrupt is low whenever busy, and reserved read bits stay zero. Other behaviour can only be shown by the bench scenarios. These cover the exact tick count to completion under irregular ticks, the committed byte contents, an abandoned write leaving the old byte in place, a read during busy leaving the buffer untouched, and a re-strobe not restarting the count.

// File: rtl/nvb_pkg.sv
package nvb_pkg;
  typedef enum logic [1:0] {
    SEL_CTL  = 2'd0,
    SEL_DATA = 2'd1,
    SEL_ADDR = 2'd2,
    SEL_NONE = 2'd3
  } nvb_sel_e;

  localparam int CTL_RIE  = 3;
  localparam int CTL_ARM  = 2;
  localparam int CTL_WSTB = 1;
  localparam int CTL_RSTB = 0;

  localparam int STALL_RD = 4;
  localparam int STALL_WR = 2;
endpackage

// File: rtl/nvb_arm.sv
module nvb_arm #(
  parameter int ARM_CYCLES = 4
) (
  input  logic clk,
  input  logic rst_n,
  input  logic set_i,
  output logic armed_o
);
  localparam int CW = (ARM_CYCLES > 1) ? $clog2(ARM_CYCLES) : 1;

  logic [CW-1:0] left_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      armed_o <= 1'b0;
      left_q  <= '0;
    end else if (set_i) begin
      armed_o <= 1'b1;
      left_q  <= CW'(ARM_CYCLES - 1);
    end else if (armed_o) begin
      if (left_q == '0) armed_o <= 1'b0;
      else              left_q  <= left_q - 1'b1;
    end
  end
endmodule

// File: rtl/nvb_wseq.sv
module nvb_wseq #(
  parameter int TICKS = 8192
) (
  input  logic clk,
  input  logic rst_n,
  input  logic start_i,
  input  logic abort_i,
  input  logic tick_i,
  output logic busy_o,
  output logic done_o
);
  localparam int CW = (TICKS > 1) ? $clog2(TICKS) : 1;

  logic [CW-1:0] cnt_q;

  assign done_o = busy_o && tick_i && !abort_i && (cnt_q == CW'(TICKS - 1));

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      busy_o <= 1'b0;
      cnt_q  <= '0;
    end else if (abort_i) begin
      busy_o <= 1'b0;
    end else if (start_i) begin
      busy_o <= 1'b1;
      cnt_q  <= '0;
    end else if (done_o) begin
      busy_o <= 1'b0;
    end else if (busy_o && tick_i) begin
      cnt_q  <= cnt_q + 1'b1;
    end
  end
endmodule

// File: rtl/nvb_store.sv
module nvb_store #(
  parameter int ADDR_W = 6,
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              we_i,
  input  logic [ADDR_W-1:0] waddr_i,
  input  logic [DATA_W-1:0] wdata_i,
  input  logic [ADDR_W-1:0] raddr_i,
  output logic [DATA_W-1:0] rdata_o
);
  localparam int DEPTH = 1 << ADDR_W;

  logic [DATA_W-1:0] cells [DEPTH];

  always_ff @(posedge clk) begin
    if (we_i) cells[waddr_i] <= wdata_i;
  end

  assign rdata_o = cells[raddr_i];
endmodule

// File: rtl/nvb_ctrl.sv
module nvb_ctrl #(
  parameter int ADDR_W      = 6,
  parameter int WRITE_TICKS = 8192,
  parameter int ARM_CYCLES  = 4,
  parameter int STALL_W     = 3
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               osc_tick,
  input  logic               reg_wr,
  input  logic [1:0]         reg_sel,
  input  logic [7:0]         reg_wdata,
  output logic [7:0]         reg_rdata,
  output logic [STALL_W-1:0] stall_cycles,
  output logic               ready_irq
);
  import nvb_pkg::*;

  localparam int REG_W = 8;
  localparam int PAD_W = REG_W - ADDR_W;

  logic              wr_ctl, wr_data, wr_addr;
  logic              armed, busy, done, rie_q;
  logic              wr_start, rd_start, abort;
  logic [ADDR_W-1:0] addr_q;
  logic [REG_W-1:0]  data_q;
  logic [REG_W-1:0]  cell_rd;
  logic [3:0]        unused_wdata;

  assign unused_wdata = reg_wdata[7:4];

  assign wr_ctl  = reg_wr && (nvb_sel_e'(reg_sel) == SEL_CTL);
  assign wr_data = reg_wr && (nvb_sel_e'(reg_sel) == SEL_DATA);
  assign wr_addr = reg_wr && (nvb_sel_e'(reg_sel) == SEL_ADDR);

  assign wr_start = wr_ctl && reg_wdata[CTL_WSTB] && armed && !busy;
  assign rd_start = wr_ctl && reg_wdata[CTL_RSTB] && !busy && !wr_start;
  assign abort    = busy && (wr_data || wr_addr);

  nvb_arm #(.ARM_CYCLES(ARM_CYCLES)) u_arm (
    .clk     (clk),
    .rst_n   (rst_n),
    .set_i   (wr_ctl && reg_wdata[CTL_ARM]),
    .armed_o (armed)
  );

  nvb_wseq #(.TICKS(WRITE_TICKS)) u_wseq (
    .clk     (clk),
    .rst_n   (rst_n),
    .start_i (wr_start),
    .abort_i (abort),
    .tick_i  (osc_tick),
    .busy_o  (busy),
    .done_o  (done)
  );

  nvb_store #(.ADDR_W(ADDR_W), .DATA_W(REG_W)) u_store (
    .clk     (clk),
    .we_i    (done),
    .waddr_i (addr_q),
    .wdata_i (data_q),
    .raddr_i (addr_q),
    .rdata_o (cell_rd)
  );

  // pointer register has no reset
  always_ff @(posedge clk) begin
    if (wr_addr) addr_q <= reg_wdata[ADDR_W-1:0];
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      data_q       <= '0;
      rie_q        <= 1'b0;
      stall_cycles <= '0;
    end else begin
      if (wr_data)       data_q <= reg_wdata;
      else if (rd_start) data_q <= cell_rd;
      if (wr_ctl) rie_q <= reg_wdata[CTL_RIE];
      if (rd_start)      stall_cycles <= STALL_W'(STALL_RD);
      else if (wr_start) stall_cycles <= STALL_W'(STALL_WR);
      else               stall_cycles <= '0;
    end
  end

  always_comb begin
    reg_rdata = '0;
    case (nvb_sel_e'(reg_sel))
      SEL_CTL: begin
        reg_rdata[CTL_RIE]  = rie_q;
        reg_rdata[CTL_ARM]  = armed;
        reg_rdata[CTL_WSTB] = busy;
      end
      SEL_DATA: reg_rdata = data_q;
      SEL_ADDR: reg_rdata = {{PAD_W{1'b0}}, addr_q};
      default:  reg_rdata = '0;
    endcase
  end

  assign ready_irq = rie_q && !busy;
endmodule

// File: rtl/nvb_ctrl_chk.sv
module nvb_ctrl_chk #(
  parameter int ARM_CYCLES = 4,
  parameter int STALL_W    = 3
) (
  input logic               clk,
  input logic               rst_n,
  input logic               reg_wr,
  input logic [1:0]         reg_sel,
  input logic [7:0]         reg_wdata,
  input logic [7:0]         reg_rdata,
  input logic [STALL_W-1:0] stall_cycles,
  input logic               ready_irq,
  input logic               armed,
  input logic               busy,
  input logic               rie
);
  logic [7:0] arm_run;

  always_ff @(posedge clk) begin
    if (!rst_n)                                      arm_run <= '0;
    else if (reg_wr && reg_sel == 2'd0 && reg_wdata[2]) arm_run <= '0;
    else if (armed && arm_run != 8'hFF)              arm_run <= arm_run + 1'b1;
    else if (!armed)                                 arm_run <= '0;
  end

  assert_arm_expiry_R3: assert property (@(posedge clk) disable iff (!rst_n)
    armed |-> (arm_run < 8'(ARM_CYCLES)));

  assert_write_needs_arm_R4: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy) |-> $past(armed));

  assert_stall_read_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (stall_cycles == STALL_W'(4)) |-> ($past(!busy) && $past(reg_wr && reg_sel == 2'd0 && reg_wdata[0])));

  assert_stall_codes_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (stall_cycles != '0) |-> ((stall_cycles == STALL_W'(2) || stall_cycles == STALL_W'(4))
                              && $past(reg_wr && reg_sel == 2'd0)));

  assert_irq_busy_low_R8: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> !ready_irq);

  assert_irq_on_finish_R8: assert property (@(posedge clk) disable iff (!rst_n)
    ($fell(busy) && rie) |-> ready_irq);

  assert_abort_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && reg_wr && (reg_sel == 2'd1 || reg_sel == 2'd2)) |=> !busy);

  assert_ctl_reserved_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_sel == 2'd0) |-> (reg_rdata[7:4] == 4'd0 && reg_rdata[0] == 1'b0));

  assert_addr_upper_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_sel == 2'd2) |-> (reg_rdata[7:6] == 2'd0));
endmodule

bind nvb_ctrl nvb_ctrl_chk #(.ARM_CYCLES(ARM_CYCLES), .STALL_W(STALL_W)) u_chk (
  .clk          (clk),
  .rst_n        (rst_n),
  .reg_wr       (reg_wr),
  .reg_sel      (reg_sel),
  .reg_wdata    (reg_wdata),
  .reg_rdata    (reg_rdata),
  .stall_cycles (stall_cycles),
  .ready_irq    (ready_irq),
  .armed        (armed),
  .busy         (busy),
  .rie          (rie_q)
);

// File: tb/nvb_ctrl_tb.sv
module nvb_ctrl_tb;
  localparam int TICKS = 32;
  localparam logic [1:0] S_CTL = 2'd0, S_DATA = 2'd1, S_ADDR = 2'd2;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       osc_tick = 1'b0;
  logic       reg_wr = 1'b0;
  logic [1:0] reg_sel = 2'd3;
  logic [7:0] reg_wdata = '0;
  logic [7:0] reg_rdata;
  logic [2:0] stall_cycles;
  logic       ready_irq;

  int n_vec = 0;
  int n_bad = 0;
  logic [7:0] model [64];
  logic       rie = 1'b0;

  always #2 clk = ~clk;

  nvb_ctrl #(.WRITE_TICKS(TICKS)) u_dut (
    .clk(clk), .rst_n(rst_n), .osc_tick(osc_tick), .reg_wr(reg_wr),
    .reg_sel(reg_sel), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
    .stall_cycles(stall_cycles), .ready_irq(ready_irq)
  );

  function automatic logic [7:0] exp_ctl(logic ie, logic arm, logic bsy);
    return {4'b0, ie, arm, bsy, 1'b0};
  endfunction

  function automatic logic [7:0] ctl_word(logic arm, logic ws, logic rs);
    return {4'b0, rie, arm, ws, rs};
  endfunction

  task automatic chk(string req, int act, int exp);
    n_vec++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
    end
  endtask

  task automatic wr(logic [1:0] s, logic [7:0] d);
    reg_wr = 1'b1; reg_sel = s; reg_wdata = d;
    @(posedge clk);
    @(negedge clk);
    reg_wr = 1'b0;
  endtask

  task automatic rdreg(logic [1:0] s, output logic [7:0] v);
    reg_sel = s;
    #1;
    v = reg_rdata;
  endtask

  task automatic idle(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic ticks(int n);
    int c = 0;
    while (c < n) begin
      logic t;
      t = 1'($urandom_range(0, 1));
      osc_tick = t;
      @(negedge clk);
      if (t) c++;
    end
    osc_tick = 1'b0;
  endtask

  // sets pointer/data, arms, strobes; returns just after acceptance edge
  task automatic start_write(logic [5:0] a, logic [7:0] d, int gap);
    wr(S_ADDR, {2'b0, a});
    wr(S_DATA, d);
    wr(S_CTL, ctl_word(1, 0, 0));
    idle(gap);
    wr(S_CTL, ctl_word(0, 1, 0));
  endtask

  task automatic full_write(logic [5:0] a, logic [7:0] d, string req);
    logic [7:0] v;
    start_write(a, d, 0);
    chk({req, " stall on write"}, stall_cycles, 2);
    ticks(TICKS - 1);
    rdreg(S_CTL, v);
    chk({req, " busy before last tick"}, v[1], 1);
    ticks(1);
    rdreg(S_CTL, v);
    chk({req, " busy after last tick"}, v[1], 0);
    model[a] = d;
  endtask

  task automatic read_back(logic [5:0] a, string req);
    logic [7:0] v;
    wr(S_ADDR, {2'b0, a});
    wr(S_CTL, ctl_word(0, 0, 1));
    chk({req, " stall on read"}, stall_cycles, 4);
    rdreg(S_DATA, v);
    chk({req, " read data"}, v, model[a]);
  endtask

  initial begin
    #(4 * 150000);
    n_bad++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end

  initial begin
    logic [7:0] v;
    void'($urandom(32'h1d5e_ed07));
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R2: reset state
    rdreg(S_CTL, v);  chk("R2 reset ctl", v, 0);
    rdreg(S_DATA, v); chk("R2 reset data", v, 0);
    chk("R2 reset stall", stall_cycles, 0);
    chk("R2 reset irq", ready_irq, 0);

    // R1: pointer width
    wr(S_ADDR, 8'hFF);
    rdreg(S_ADDR, v); chk("R1 pointer readback", v, 8'h3F);

    // R2: control layout, R8 irq level
    wr(S_CTL, 8'hFC);
    rie = 1'b1;
    rdreg(S_CTL, v); chk("R2 ctl layout", v, exp_ctl(1, 1, 0));
    chk("R8 irq idle enabled", ready_irq, 1);
    idle(5);

    // fill store
    for (int i = 0; i < 64; i++) full_write(6'(i), 8'($urandom), "R5");

    // R3: arm window edges
    for (int g = 0; g < 5; g++) begin
      logic [7:0] d = 8'($urandom);
      start_write(6'(g), d, g);
      rdreg(S_CTL, v);
      if (g < 4) begin
        chk("R3 strobe within window", v[1], 1);
        chk("R8 irq low while busy", ready_irq, 0);
        ticks(TICKS);
        model[g] = d;
      end else begin
        chk("R3 strobe after window", v[1], 0);
        chk("R4 no stall unarmed", stall_cycles, 0);
      end
      read_back(6'(g), "R3");
    end

    // R3: arm bit lifetime
    wr(S_CTL, ctl_word(1, 0, 0));
    idle(3); rdreg(S_CTL, v); chk("R3 arm live 4th cycle", v[2], 1);
    idle(1); rdreg(S_CTL, v); chk("R3 arm lapsed", v[2], 0);

    // R4: strobe without arming
    wr(S_DATA, 8'h5A);
    wr(S_CTL, ctl_word(0, 1, 0));
    chk("R4 no stall", stall_cycles, 0);
    rdreg(S_CTL, v); chk("R4 not busy", v[1], 0);
    ticks(TICKS + 2);
    read_back(6'd63, "R4");

    // R9: abort via data edit
    start_write(6'd10, ~model[10], 0);
    ticks(5);
    wr(S_DATA, 8'h11);
    rdreg(S_CTL, v); chk("R9 abort data clears busy", v[1], 0);
    ticks(TICKS);
    read_back(6'd10, "R9");

    // R9: abort via pointer edit
    start_write(6'd11, ~model[11], 0);
    wr(S_ADDR, 8'd12);
    rdreg(S_CTL, v); chk("R9 abort pointer clears busy", v[1], 0);
    ticks(TICKS);
    read_back(6'd11, "R9");
    read_back(6'd12, "R9");

    // R10: read during busy ignored, R11: re-strobe ignored
    start_write(6'd20, 8'hC3, 0);
    wr(S_CTL, ctl_word(0, 0, 1));
    chk("R10 no stall", stall_cycles, 0);
    rdreg(S_DATA, v); chk("R10 buffer kept", v, 8'hC3);
    ticks(10);
    wr(S_CTL, ctl_word(1, 0, 0));
    wr(S_CTL, ctl_word(0, 1, 0));
    chk("R11 no stall", stall_cycles, 0);
    ticks(TICKS - 11);
    rdreg(S_CTL, v); chk("R11 busy before end", v[1], 1);
    ticks(1);
    rdreg(S_CTL, v); chk("R11 done at original count", v[1], 0);
    chk("R8 irq back high", ready_irq, 1);
    model[20] = 8'hC3;
    read_back(6'd20, "R11");

    // R7: stall pulse is one cycle
    wr(S_CTL, ctl_word(0, 0, 1));
    idle(1);
    chk("R7 stall cleared", stall_cycles, 0);

    // R8: irq disabled
    rie = 1'b0;
    wr(S_CTL, ctl_word(0, 0, 0));
    chk("R8 irq disabled", ready_irq, 0);
    rie = 1'b1;
    wr(S_CTL, ctl_word(0, 0, 0));

    // random mix
    for (int k = 0; k < 40; k++) begin
      logic [5:0] a = 6'($urandom);
      case ($urandom_range(0, 2))
        0: full_write(a, 8'($urandom), "R5");
        1: read_back(a, "R6");
        default: begin
          start_write(a, ~model[a], 0);
          ticks($urandom_range(0, TICKS - 2));
          wr(S_DATA, 8'($urandom));
          rdreg(S_CTL, v); chk("R9 random abort", v[1], 0);
          read_back(a, "R9");
        end
      endcase
    end

    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end
endmodule